// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small accumulator processor that runs one instruction at a time. Every instruction passes through a fetch phase, a decode step and an execute phase. Each phase is broken into single register transfers. The program counter, memory address register, memory data register, current instruction register and accumulator are all brought out as ports so the transfers can be watched.

Instructions and data share one single-port synchronous memory with a one-cycle read latency. Every access goes through the memory address register and the memory data register. A fetched word is copied into the instruction register before decode. The program counter advances during fetch, so a jump executed later overwrites the value that has already been incremented.

The core adds, subtracts and compares against memory operands. It stores the accumulator, jumps, presents the accumulator on an output port, and halts.

Top module: `acc_cpu`

## Requirements
- R1: Fetch takes five steps, in this order:
  - MAR takes PC.
  - One wait cycle follows while the memory reads.
  - MDR takes the read data.
  - CIR takes MDR.
  - PC becomes PC+1.
  
  A decode cycle follows.
- R2: PC changes only in two ways: by +1 in the last fetch step, or by a jump load. It does not change during the other fetch steps.
- R3: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the operand address. The opcode values are: load=1, store=2, add=3, subtract=4, compare=5, jump=6, output=7, halt=0xF.
- R4: Load, add and subtract each do the same first steps: MAR takes the operand, one wait cycle follows, and MDR latches the read data. Then ACC becomes MDR (load), ACC+MDR (add) or ACC−MDR (subtract). Results wrap modulo 2^16.
- R5: Store does three steps: MAR takes the operand, MDR takes ACC, then one write cycle puts MDR at MAR. During that cycle write enable is high and the write data equals ACC.
- R6: Jump loads the operand into PC. The next fetch comes from that address, and the word after the jump is not executed.
- R7: Compare reads its operand and sets two flags from ACC−MDR: zero when the result is 0, negative when bit 15 of the result is 1. It leaves ACC unchanged. No other instruction alters the flags.
- R8: Output raises out_valid_o for exactly one cycle, with out_data_o equal to ACC.
- R9: Halt raises halted_o. After that, PC stays frozen and no memory write occurs until reset.
- R10: Any opcode not listed in R3 (0 and 8 to 0xE) acts as a no-op: ACC, the flags and memory are unchanged, and fetch continues at PC+1.
- R11: While reset is asserted, the state is as follows:
  - PC equals RESET_VEC (default 100).
  - ACC, MAR, MDR, CIR and both flags are zero.
  - halted_o is low.
  
  After release the core starts a fetch.
- R12: The program at 100..102 (load 200, add 201, store 202), with 15 and 27 at 200 and 201, writes 42 to 202. PC reads 103 during the store's write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory address (driven by MAR) |
| mem_wdata_o | output | 16 | Memory write data (driven by MDR) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after the address |
| out_data_o | output | 16 | Output port data |
| out_valid_o | output | 1 | Output port strobe |
| halted_o | output | 1 | Core has halted |
| pc_o | output | 12 | Program counter |
| mar_o | output | 12 | Memory address register |
| mdr_o | output | 16 | Memory data register |
| cir_o | output | 16 | Current instruction register |
| acc_o | output | 16 | Accumulator |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
The bench builds the core with its default 16-bit word and a reset vector of 100. This lets the three-instruction example run unchanged from its own addresses, and the 12-bit address range covers both the jump target and the data area. A second program sets up two situations in one run: a jump that skips a store, and a compare whose difference borrows. These check the negative flag and confirm that the skipped write never reaches memory. The bench also follows the fetch transfers one cycle at a time after reset.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LDA = 4'h1;
  localparam logic [OPC_W-1:0] OP_STO = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h4;
  localparam logic [OPC_W-1:0] OP_CMP = 4'h5;
  localparam logic [OPC_W-1:0] OP_JMP = 4'h6;
  localparam logic [OPC_W-1:0] OP_OUT = 4'h7;
  localparam logic [OPC_W-1:0] OP_HLT = 4'hF;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;

  typedef enum logic [3:0] {
    S_F_MAR, S_F_WAIT, S_F_MDR, S_F_CIR, S_F_INC, S_DEC,
    S_X_MAR, S_X_WAIT, S_X_MDR, S_X_ALU, S_X_ACC2MDR, S_X_WRITE,
    S_X_JMP, S_X_OUT, S_HALT
  } state_e;

  typedef struct packed {
    logic    rd_opnd;
    logic    is_store;
    logic    is_jump;
    logic    is_out;
    logic    is_halt;
    logic    wr_acc;
    logic    wr_flags;
    alu_op_e alu_op;
  } dec_t;

  typedef struct packed {
    logic ld_mar_pc;
    logic ld_mar_opnd;
    logic ld_mdr_mem;
    logic ld_mdr_acc;
    logic ld_cir;
    logic inc_pc;
    logic ld_pc_opnd;
    logic ld_acc;
    logic ld_flags;
    logic mem_we;
    logic out_valid;
    logic halted;
  } ctl_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '0;
    dec_o.alu_op = ALU_PASS;
    case (opc_i)
      OP_LDA: begin dec_o.rd_opnd = 1'b1; dec_o.wr_acc = 1'b1; end
      OP_ADD: begin dec_o.rd_opnd = 1'b1; dec_o.wr_acc = 1'b1; dec_o.alu_op = ALU_ADD; end
      OP_SUB: begin dec_o.rd_opnd = 1'b1; dec_o.wr_acc = 1'b1; dec_o.alu_op = ALU_SUB; end
      OP_CMP: begin dec_o.rd_opnd = 1'b1; dec_o.wr_flags = 1'b1; dec_o.alu_op = ALU_SUB; end
      OP_STO: dec_o.is_store = 1'b1;
      OP_JMP: dec_o.is_jump  = 1'b1;
      OP_OUT: dec_o.is_out   = 1'b1;
      OP_HLT: dec_o.is_halt  = 1'b1;
      default: ;  // unknown opcode: no-op
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o,
  output logic         neg_o
);
  logic [W-1:0] diff;

  assign diff   = a_i - b_i;
  assign zero_o = (diff == '0);
  assign neg_o  = diff[W-1];

  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = diff;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  dec_t   dec_i,
  output ctl_t   ctl_o,
  output state_e state_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_MAR;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_F_MAR:  state_d = S_F_WAIT;
      S_F_WAIT: state_d = S_F_MDR;
      S_F_MDR:  state_d = S_F_CIR;
      S_F_CIR:  state_d = S_F_INC;
      S_F_INC:  state_d = S_DEC;
      S_DEC: begin
        if (dec_i.is_halt)                          state_d = S_HALT;
        else if (dec_i.is_jump)                     state_d = S_X_JMP;
        else if (dec_i.is_out)                      state_d = S_X_OUT;
        else if (dec_i.rd_opnd || dec_i.is_store)   state_d = S_X_MAR;
        else                                        state_d = S_F_MAR;
      end
      S_X_MAR:     state_d = dec_i.is_store ? S_X_ACC2MDR : S_X_WAIT;
      S_X_WAIT:    state_d = S_X_MDR;
      S_X_MDR:     state_d = S_X_ALU;
      S_X_ALU:     state_d = S_F_MAR;
      S_X_ACC2MDR: state_d = S_X_WRITE;
      S_X_WRITE:   state_d = S_F_MAR;
      S_X_JMP:     state_d = S_F_MAR;
      S_X_OUT:     state_d = S_F_MAR;
      S_HALT:      state_d = S_HALT;
      default:     state_d = S_F_MAR;
    endcase
  end

  always_comb begin
    ctl_o = '0;
    case (state_q)
      S_F_MAR:     ctl_o.ld_mar_pc   = 1'b1;
      S_F_MDR:     ctl_o.ld_mdr_mem  = 1'b1;
      S_F_CIR:     ctl_o.ld_cir      = 1'b1;
      S_F_INC:     ctl_o.inc_pc      = 1'b1;
      S_X_MAR:     ctl_o.ld_mar_opnd = 1'b1;
      S_X_MDR:     ctl_o.ld_mdr_mem  = 1'b1;
      S_X_ALU: begin
        ctl_o.ld_acc   = dec_i.wr_acc;
        ctl_o.ld_flags = dec_i.wr_flags;
      end
      S_X_ACC2MDR: ctl_o.ld_mdr_acc  = 1'b1;
      S_X_WRITE:   ctl_o.mem_we      = 1'b1;
      S_X_JMP:     ctl_o.ld_pc_opnd  = 1'b1;
      S_X_OUT:     ctl_o.out_valid   = 1'b1;
      S_HALT:      ctl_o.halted      = 1'b1;
      default: ;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int RESET_VEC = 100,
  localparam int ADDR_W    = DATA_W - OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] cir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              neg_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q;
  logic              zero_q, neg_q;
  logic [ADDR_W-1:0] opnd;
  dec_t              dec;
  ctl_t              ctl;
  state_e            state_q;
  logic [DATA_W-1:0] alu_y;
  logic              alu_zero, alu_neg;

  assign opnd = cir_q[ADDR_W-1:0];

  acc_cpu_decode u_dec (
    .opc_i (cir_q[DATA_W-1 -: OPC_W]),
    .dec_o (dec)
  );

  acc_cpu_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (dec),
    .ctl_o   (ctl),
    .state_o (state_q)
  );

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a_i    (acc_q),
    .b_i    (mdr_q),
    .op_i   (dec.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero),
    .neg_o  (alu_neg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= ADDR_W'(RESET_VEC);
      mar_q  <= '0;
      mdr_q  <= '0;
      cir_q  <= '0;
      acc_q  <= '0;
      zero_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      if (ctl.ld_mar_pc)        mar_q <= pc_q;
      else if (ctl.ld_mar_opnd) mar_q <= opnd;
      if (ctl.ld_mdr_mem)       mdr_q <= mem_rdata_i;
      else if (ctl.ld_mdr_acc)  mdr_q <= acc_q;
      if (ctl.ld_cir)           cir_q <= mdr_q;
      if (ctl.inc_pc)           pc_q  <= pc_q + 1'b1;
      else if (ctl.ld_pc_opnd)  pc_q  <= opnd;
      if (ctl.ld_acc)           acc_q <= alu_y;
      if (ctl.ld_flags) begin
        zero_q <= alu_zero;
        neg_q  <= alu_neg;
      end
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_we_o    = ctl.mem_we;
  assign out_data_o  = acc_q;
  assign out_valid_o = ctl.out_valid;
  assign halted_o    = ctl.halted;
  assign pc_o        = pc_q;
  assign mar_o       = mar_q;
  assign mdr_o       = mdr_q;
  assign cir_o       = cir_q;
  assign acc_o       = acc_q;
  assign zero_o      = zero_q;
  assign neg_o       = neg_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input state_e            state_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] mdr_i,
  input logic [DATA_W-1:0] cir_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              zero_i,
  input logic              neg_i,
  input logic              halted_i,
  input logic              mem_we_i,
  input logic [DATA_W-1:0] mem_wdata_i
);
  p_cir_from_mdr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cir_i) |-> cir_i == $past(mdr_i));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pc_i) && $past(state_i) != S_X_JMP) |-> pc_i == $past(pc_i) + 1'b1);

  p_jump_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_i) == S_X_JMP |-> pc_i == $past(cir_i[ADDR_W-1:0]));

  p_store_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (mem_wdata_i == acc_i && $past(state_i) == S_X_ACC2MDR));

  p_flags_cmp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({zero_i, neg_i}) |->
      ($past(state_i) == S_X_ALU && $past(cir_i[DATA_W-1 -: OPC_W]) == OP_CMP));

  p_halt_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> (halted_i && $stable(pc_i) && !mem_we_i));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state_q),
  .pc_i        (pc_o),
  .mdr_i       (mdr_o),
  .cir_i       (cir_o),
  .acc_i       (acc_o),
  .zero_i      (zero_o),
  .neg_i       (neg_o),
  .halted_i    (halted_o),
  .mem_we_i    (mem_we_o),
  .mem_wdata_i (mem_wdata_o)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 12;

  typedef struct packed {
    logic          is_out;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we;
  logic [DW-1:0] out_data;
  logic          out_valid, halted;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, cir, acc;
  logic          zero, neg;

  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] mem [1<<AW];

  int    n_cmp = 0, n_bad = 0, out_seen = 0;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu #(.DATA_W(DW), .RESET_VEC(100)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata),
    .out_data_o(out_data), .out_valid_o(out_valid), .halted_o(halted),
    .pc_o(pc), .mar_o(mar), .mdr_o(mdr), .cir_o(cir), .acc_o(acc),
    .zero_o(zero), .neg_o(neg)
  );

  // synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (ld_we)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] w(input logic [3:0] opc, input int a);
    return {opc, AW'(a)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_wr(input int a, input logic [DW-1:0] d);
    exp_q.push_back('{is_out: 1'b0, addr: AW'(a), data: d});
  endtask

  task automatic push_out(input logic [DW-1:0] d);
    exp_q.push_back('{is_out: 1'b1, addr: '0, data: d});
  endtask

  // monitor: compare produced writes / outputs against scoreboard
  always @(negedge clk) begin
    if (rst_n && (mem_we || out_valid)) begin
      n_cmp++;
      if (out_valid) out_seen++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R8: unexpected event out=%0b addr=%0h data=%0h expected none",
                 out_valid, mem_addr, out_valid ? out_data : mem_wdata);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e.is_out != out_valid ||
            (out_valid ? out_data : mem_wdata) != e.data ||
            (!out_valid && mem_addr != e.addr)) begin
          n_bad++;
          $display("FAIL R5/R8: actual out=%0b addr=%0h data=%0h expected out=%0b addr=%0h data=%0h",
                   out_valid, mem_addr, out_valid ? out_data : mem_wdata, e.is_out, e.addr, e.data);
        end
      end
    end
  end

  task automatic load(input int a, input logic [DW-1:0] d);
    ld_addr = AW'(a); ld_data = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic clear_mem;
    for (int a = 96; a < 256; a++) load(a, '0);
  endtask

  task automatic wait_halt;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    clear_mem();
    // program 1
    load(100, w(4'h1, 200));
    load(101, w(4'h3, 201));
    load(102, w(4'h2, 202));
    load(103, w(4'hF, 0));
    load(200, 16'd15);
    load(201, 16'd27);

    // R11 reset state
    chk("R11 pc", DW'(pc), 16'd100);
    chk("R11 acc", acc, 0);
    chk("R11 mar", DW'(mar), 0);
    chk("R11 mdr", mdr, 0);
    chk("R11 cir", cir, 0);
    chk("R11 flags", {14'd0, zero, neg}, 0);
    chk("R11 halted", DW'(halted), 0);

    rst_n = 1'b1;
    @(negedge clk);                       // after MAR<=PC
    chk("R1 mar=pc", DW'(mar), 16'd100);
    chk("R2 pc held", DW'(pc), 16'd100);
    @(negedge clk); @(negedge clk);       // wait, then MDR<=mem
    chk("R1 mdr", mdr, 16'h10C8);
    chk("R1 cir before copy", cir, 0);
    @(negedge clk);                       // CIR<=MDR
    chk("R3 cir word", cir, 16'h10C8);
    chk("R2 pc before inc", DW'(pc), 16'd100);
    @(negedge clk);                       // PC+1
    chk("R2 pc inc", DW'(pc), 16'd101);

    push_wr(202, 16'd42);
    for (int i = 0; i < 200 && !mem_we; i++) @(negedge clk);
    chk("R12 pc at store", DW'(pc), 16'd103);
    wait_halt();
    chk("R12 mem[202]", mem[202], 16'd42);
    chk("R4 acc", acc, 16'd42);
    chk("R9 halted", DW'(halted), 1);
    chk("R9 pc after halt", DW'(pc), 16'd104);
    repeat (20) @(negedge clk);
    chk("R9 pc frozen", DW'(pc), 16'd104);
    chk("R9 still halted", DW'(halted), 1);

    // program 2
    rst_n = 1'b0;
    clear_mem();
    load(100, w(4'h1, 210));   // LDA 50
    load(101, w(4'h4, 211));   // SUB 12 -> 38
    load(102, w(4'h7, 0));     // OUT
    load(103, w(4'h5, 212));   // CMP 38 -> zero
    load(104, w(4'h7, 0));     // OUT
    load(105, w(4'h6, 120));   // JMP 120
    load(106, w(4'h2, 215));   // skipped store
    load(120, w(4'h8, 291));   // unknown opcode
    load(121, 16'h0000);       // opcode 0
    load(122, w(4'h5, 213));   // CMP 40 -> negative
    load(123, w(4'h2, 214));   // STO
    load(124, w(4'hF, 0));
    load(210, 16'd50);
    load(211, 16'd12);
    load(212, 16'd38);
    load(213, 16'd40);
    chk("R11 halted cleared", DW'(halted), 0);
    chk("R11 pc revector", DW'(pc), 16'd100);
    push_out(16'd38);
    push_out(16'd38);
    push_wr(214, 16'd38);
    out_seen = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 500 && out_seen < 2; i++) @(negedge clk);
    @(negedge clk);
    chk("R7 zero after equal cmp", DW'(zero), 1);
    chk("R7 neg after equal cmp", DW'(neg), 0);
    chk("R7 acc kept", acc, 16'd38);
    wait_halt();
    chk("R4 sub result", acc, 16'd38);
    chk("R7 neg on borrow", DW'(neg), 1);
    chk("R7 zero clear", DW'(zero), 0);
    chk("R6 skipped store", mem[215], 0);
    chk("R10 pc after no-ops", DW'(pc), 16'd125);
    chk("R5 mem[214]", mem[214], 16'd38);
    chk("R8 all events seen", DW'(exp_q.size()), 0);
    finish_run();
  end
endmodule